// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator with Weighted Output

This block is the oscillator of a digital phase-locked loop. Each clock cycle it adds a programmable phase increment to a 32-bit phase accumulator. With a 31.25 MHz clock, one increment count is worth about 0.007276 Hz, so the frequency is the clock rate times the increment divided by 2^32. A quarter-wave sine table is computed when the design is built. It is read with quadrant folding, and the oscillator gives a sine and a cosine sample on the same cycle.

The feedback pair (cosine and sine) goes back to the loop's phase detector. A divide-by-two mode can feed that pair from the accumulator phase halved. The loop then locks the halved oscillation to its input, so the main oscillation runs at twice the input frequency. A separate output lookup always uses the full phase. Its cosine and sine are each multiplied by a signed weight and summed, and the sum is rounded and saturated into one real output sample. The two weights together set both the amplitude and the phase of the output. Because of this, the phase resolution becomes coarse when the amplitude is small.

Top module: `nco_quad`

## Requirements
- R1: While `rst` is high, on each clock edge the phase is set to zero, `fb_cos`, `fb_sin` and `out_sample` become 0 and `wrap_tick` becomes 0. After release, the first sample produced corresponds to phase zero.
- R2: The phase grows by `phase_inc` modulo 2^32 on every clock edge. `wrap_tick` is high for the one cycle after each edge on which the phase wraps. Over the first W edges after reset, the number of ticks is floor(W·inc/2^32).
- R3: For a 12-bit circle address a (the top 12 phase bits), the sine sample is s(a) = sign·round(8191·|sin(2π(a+½)/4096)|). Rounding is half away from zero.
- R4: The cosine sample for address a is s((a+1024) mod 4096), a quarter turn ahead of the sine.
- R5: `fb_cos` and `fb_sin` after clock edge m show the phase held after edge m−2. When the phase after edge k is k·inc, the address after edge m is therefore ((m−2)·inc mod 2^32) >> 20.
- R6: With `half_rate` high, the feedback address is the top 12 bits of a 33-bit phase that counts wraps. After edge m this is ((m−2)·inc mod 2^33) >> 21, which is half the frequency. The output path still uses the full 32-bit phase.
- R7: `out_sample` after edge m is floor((wc·c + ws·s + 2^13) / 2^14). Here wc is `cos_weight` and ws is `sin_weight`, both signed, with 2^14 meaning unity. c and s are the full-phase cosine and sine samples at phase (m−4)·inc.
- R8: A weighted sum outside [−8192, 8191] is clamped to the nearest bound.
- R9: With `phase_inc` zero, the phase holds and every output stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_inc | input | 32 | Phase increment per cycle (frequency word) |
| half_rate | input | 1 | Feed the feedback pair from the halved phase |
| cos_weight | input | 16 | Signed cosine weight, 2^14 = 1.0 |
| sin_weight | input | 16 | Signed sine weight, 2^14 = 1.0 |
| fb_cos | output | 14 | Signed feedback cosine |
| fb_sin | output | 14 | Signed feedback sine |
| out_sample | output | 14 | Signed weighted real output |
| wrap_tick | output | 1 | One-cycle pulse on each phase wrap |

## Verification
A wrong accumulator value shifts every later sample and changes the wrap-tick count. A wrong address or pipeline depth shows as a mismatch at the feedback ports two cycles later and at the weighted output four cycles later. A bad table entry or a wrong fold shows within one sweep of the circle: every address is visited once per 4096 cycles at the unit-step increment, and every address once per 8192 cycles in divide mode. Errors in rounding or clamping in the combiner show on the first sample whose weighted sum crosses a rounding boundary or the 14-bit limit.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Magnitude of one quarter-wave entry, sampled at the middle of its slot
  // so that mirrored quadrants reuse the same entries exactly.
  function automatic int quarter_sample(int k, int qdepth, int amp);
    real ang;
    ang = TWO_PI * (real'(k) + 0.5) / (4.0 * real'(qdepth));
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] inc,
  output logic [ADDR_W:0]    phase_top,
  output logic               wrap
);

  // One extra bit above the phase counts wraps, giving a half-rate phase.
  logic [PHASE_W:0] acc;
  logic [PHASE_W:0] nxt;

  assign nxt       = {1'b0, acc[PHASE_W-1:0]} + {1'b0, inc};
  assign phase_top = acc[PHASE_W -: ADDR_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      wrap <= 1'b0;
    end else begin
      acc  <= {acc[PHASE_W] ^ nxt[PHASE_W], nxt[PHASE_W-1:0]};
      wrap <= nxt[PHASE_W];
    end
  end

  // R1: first cycle after reset starts from phase zero
  a_r1_phase_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc == '0 && !wrap));

  // R2: increments below half a turn cannot wrap on two cycles in a row
  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    (wrap && !inc[PHASE_W-1] && !$past(inc[PHASE_W-1])) |=> !wrap);

  // R9: a zero increment holds the phase
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inc) == '0) |-> (acc == $past(acc)));

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut #(
  parameter int ADDR_W = 12,
  parameter int SAMP_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] sin_o,
  output logic signed [SAMP_W-1:0] cos_o
);

  localparam int QA     = ADDR_W - 2;
  localparam int QDEPTH = 1 << QA;
  localparam int AMP    = (1 << (SAMP_W-1)) - 1;
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(QDEPTH);

  // Positive quarter-wave magnitudes, one read port per quadrature lane.
  logic [SAMP_W-2:0] rom [QDEPTH];

  initial begin
    for (int k = 0; k < QDEPTH; k++)
      rom[k] = (SAMP_W-1)'(nco_pkg::quarter_sample(k, QDEPTH, AMP));
  end

  logic [ADDR_W-1:0]        lane_addr [2];
  logic signed [SAMP_W-1:0] lane_out  [2];

  assign lane_addr[0] = addr;            // sine
  assign lane_addr[1] = addr + QUARTER;  // cosine leads by a quarter turn

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic              mirror;
    logic              negate;
    logic [QA-1:0]     idx;
    logic [SAMP_W-2:0] mag_q;
    logic              neg_q;

    assign mirror = lane_addr[g][ADDR_W-2];
    assign negate = lane_addr[g][ADDR_W-1];
    assign idx    = mirror ? ~lane_addr[g][QA-1:0] : lane_addr[g][QA-1:0];

    always_ff @(posedge clk) begin
      if (rst) begin
        mag_q <= '0;
        neg_q <= 1'b0;
      end else begin
        mag_q <= rom[idx];
        neg_q <= negate;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)        lane_out[g] <= '0;
      else if (neg_q) lane_out[g] <= -$signed({1'b0, mag_q});
      else            lane_out[g] <=  $signed({1'b0, mag_q});
    end
  end

  assign sin_o = lane_out[0];
  assign cos_o = lane_out[1];

endmodule

// File: rtl/nco_mix.sv
module nco_mix #(
  parameter int SAMP_W = 14,
  parameter int WGT_W  = 16,
  parameter int OUT_W  = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [SAMP_W-1:0] cos_in,
  input  logic signed [SAMP_W-1:0] sin_in,
  input  logic signed [WGT_W-1:0]  w_cos,
  input  logic signed [WGT_W-1:0]  w_sin,
  output logic signed [OUT_W-1:0]  y
);

  localparam int FRAC = WGT_W - 2;
  localparam int PW   = SAMP_W + WGT_W;
  localparam int SW   = PW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC-1);
  localparam logic signed [SW-1:0] HI   = SW'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SW-1:0] LO   = -HI - SW'(1);

  logic signed [PW-1:0] prod_c, prod_s;
  logic signed [SW-1:0] total, rnd, shr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_c <= '0;
      prod_s <= '0;
    end else begin
      prod_c <= PW'(w_cos * cos_in);
      prod_s <= PW'(w_sin * sin_in);
    end
  end

  assign total = SW'(prod_c) + SW'(prod_s);
  assign rnd   = total + HALF;
  assign shr   = rnd >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst)            y <= '0;
    else if (shr > HI)  y <= HI[OUT_W-1:0];
    else if (shr < LO)  y <= LO[OUT_W-1:0];
    else                y <= shr[OUT_W-1:0];
  end

endmodule

// File: rtl/nco_quad.sv
module nco_quad #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 12,
  parameter int SAMP_W  = 14,
  parameter int WGT_W   = 16,
  parameter int OUT_W   = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       phase_inc,
  input  logic                     half_rate,
  input  logic signed [WGT_W-1:0]  cos_weight,
  input  logic signed [WGT_W-1:0]  sin_weight,
  output logic signed [SAMP_W-1:0] fb_cos,
  output logic signed [SAMP_W-1:0] fb_sin,
  output logic signed [OUT_W-1:0]  out_sample,
  output logic                     wrap_tick
);

  localparam int NLUT = 2;
  localparam int FB   = 0;
  localparam int OUTP = 1;
  localparam logic signed [WGT_W-1:0] UNITY = WGT_W'(1) <<< (WGT_W-2);

  logic [ADDR_W:0] phase_top;

  nco_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .inc(phase_inc),
    .phase_top(phase_top), .wrap(wrap_tick)
  );

  logic [ADDR_W-1:0]        lut_addr [NLUT];
  logic signed [SAMP_W-1:0] lut_sin  [NLUT];
  logic signed [SAMP_W-1:0] lut_cos  [NLUT];

  // Feedback lane may take the halved phase; output lane always full phase.
  assign lut_addr[FB]   = half_rate ? phase_top[ADDR_W:1] : phase_top[ADDR_W-1:0];
  assign lut_addr[OUTP] = phase_top[ADDR_W-1:0];

  for (genvar g = 0; g < NLUT; g++) begin : g_lut
    nco_quarter_lut #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_lut (
      .clk(clk), .rst(rst), .addr(lut_addr[g]),
      .sin_o(lut_sin[g]), .cos_o(lut_cos[g])
    );
  end

  assign fb_cos = lut_cos[FB];
  assign fb_sin = lut_sin[FB];

  nco_mix #(.SAMP_W(SAMP_W), .WGT_W(WGT_W), .OUT_W(OUT_W)) u_mix (
    .clk(clk), .rst(rst),
    .cos_in(lut_cos[OUTP]), .sin_in(lut_sin[OUTP]),
    .w_cos(cos_weight), .w_sin(sin_weight), .y(out_sample)
  );

  // R6: without halving, both lanes see the same phase
  a_r6_lanes_agree: assert property (@(posedge clk) disable iff (rst)
    (!$past(half_rate, 2) && !$past(rst) && !$past(rst, 2))
      |-> (lut_sin[FB] == lut_sin[OUTP] && lut_cos[FB] == lut_cos[OUTP]));

  // R7: unity cosine weight and zero sine weight pass the cosine through
  a_r7_unity_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) &&
     $past(cos_weight, 2) == UNITY && $past(sin_weight, 2) == '0)
      |-> (OUT_W'(out_sample) == OUT_W'($past(lut_cos[OUTP], 2))));

endmodule

// File: tb/nco_quad_bench.sv
`timescale 1ns/1ps
module nco_quad_bench;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [31:0]        phase_inc = '0;
  logic               half_rate = 1'b0;
  logic signed [15:0] cos_weight = '0;
  logic signed [15:0] sin_weight = '0;
  logic signed [13:0] fb_cos, fb_sin, out_sample;
  logic               wrap_tick;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nco_quad u_nco_quad (
    .clk(clk), .rst(rst), .phase_inc(phase_inc), .half_rate(half_rate),
    .cos_weight(cos_weight), .sin_weight(sin_weight),
    .fb_cos(fb_cos), .fb_sin(fb_sin), .out_sample(out_sample),
    .wrap_tick(wrap_tick)
  );

  function automatic int exp_sin(int a);
    real v;
    v = 8191.0 * $sin(6.283185307179586 * (real'(a & 4095) + 0.5) / 4096.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int exp_cos(int a);
    return exp_sin(a + 1024);
  endfunction

  function automatic int exp_mix(int c, int s, int wc, int ws);
    longint acc;
    acc = longint'(wc) * c + longint'(ws) * s + 64'sd8192;
    acc = acc >>> 14;
    if (acc > 8191) return 8191;
    if (acc < -8192) return -8192;
    return int'(acc);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_case(logic [31:0] inc, bit div, int wc, int ws, int ncyc,
                          string fb_tag, string out_tag);
    int ticks;
    longint unsigned prod;
    int a_fb, a_out;
    ticks = 0;
    rst = 1'b1;
    phase_inc  = inc;
    half_rate  = div;
    cos_weight = 16'(wc);
    sin_weight = 16'(ws);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared by reset
    chk("R1", "fb_cos in reset", int'(fb_cos), 0);
    chk("R1", "fb_sin in reset", int'(fb_sin), 0);
    chk("R1", "out in reset", int'(out_sample), 0);
    chk("R1", "tick in reset", int'(wrap_tick), 0);
    rst = 1'b0;
    for (int m = 1; m <= ncyc; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (wrap_tick) ticks++;
      if (m >= 2) begin
        prod = longint'(m - 2) * 64'(inc);
        if (div) a_fb = int'((prod & 64'h1_FFFF_FFFF) >> 21);
        else     a_fb = int'((prod & 64'h0_FFFF_FFFF) >> 20);
        chk(fb_tag, "fb_sin", int'(fb_sin), exp_sin(a_fb));
        chk(fb_tag, "fb_cos", int'(fb_cos), exp_cos(a_fb));
      end
      if (m >= 4) begin
        prod  = longint'(m - 4) * 64'(inc);
        a_out = int'((prod & 64'h0_FFFF_FFFF) >> 20);
        chk(out_tag, "out_sample", int'(out_sample),
            exp_mix(exp_cos(a_out), exp_sin(a_out), wc, ws));
      end
    end
    // R2: wrap ticks over the window
    prod = (longint'(ncyc) * 64'(inc)) >> 32;
    chk("R2", "tick count", ticks, int'(prod));
  endtask

  initial begin
    // R3 R5: unit address step sweeps every table address; R7 unity weight
    run_case(32'h0010_0000, 1'b0, 16384, 0, 4200, "R3 R5", "R7");
    // R6: halved feedback phase sweeps the circle in 8192 cycles
    run_case(32'h0010_0000, 1'b1, 3000, -7000, 8300, "R6", "R6");
    // R4: irregular increment, mixed-sign weights
    run_case(32'h0123_4567, 1'b0, -9000, 12000, 3000, "R3 R4", "R7");
    // R8: large weights force clamping at both bounds
    run_case(32'h00A0_0000, 1'b0, 32767, 32767, 3000, "R3", "R8");
    run_case(32'h00B3_0000, 1'b0, -32768, -32768, 2000, "R3", "R8");
    // R9: zero increment holds every output
    run_case(32'h0000_0000, 1'b0, 16384, 16384, 60, "R9", "R9");
    // R2: wrap count with a non-power-of-two increment
    run_case(32'h1234_5678, 1'b0, 0, 0, 1000, "R2", "R7");
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule